// File: doc/BRIEF.md
# Packed Two-Entry Palette Table

This block is a 256-entry colour lookup table for an indexed-colour pixel pipeline. Each entry is a 16-bit half-word that holds a 15-bit colour with five bits each of red, green and blue. Two entries share one 32-bit storage word, so the table is 128 words deep. Software reaches the table through a word-addressed register port with per-byte write enables. Read and write can both be issued in the same cycle. The pixel path presents an 8-bit index and receives the three 5-bit channels one cycle later.

The word for index n is n shifted right by one. The low index bit picks the half-word. A byte-order control input inverts that choice, so a table written as big-endian words still returns the right entry for each index. Storage is split into byte-lane memories. Each lane has a register port and a pixel read port, so an FPGA can map each lane onto a true dual-port block RAM.

Top module: `hw_palette`

## Requirements
- R1: The table has 256 entries, addressed on the pixel side by an 8-bit index. Entries 2k and 2k+1 both live in register word k, and the register word address is 7 bits wide.
- R2: When `swap_bytes` is 0, an even index reads bits 15:0 of its word and an odd index reads bits 31:16.
- R3: When `swap_bytes` is 1, the low index bit is inverted before the half-word is chosen. An even index then reads bits 31:16 and an odd index reads bits 15:0. `swap_bytes` is sampled in the same cycle as `pix_req`.
- R4: Within a half-word, `pix_red` comes from bits 4:0, `pix_grn` from bits 9:5 and `pix_blu` from bits 14:10.
- R5: Bit 15 of each half-word is stored and returned by register reads. It never affects the pixel outputs.
- R6: `reg_be[i]` enables writing of bits 8i+7:8i. All lanes without their enable set, including the other entry in the same word, keep their contents.
- R7: `pix_valid` is high in exactly the cycle after a cycle with `pix_req` high. The colour outputs update only after a request and otherwise hold their value.
- R8: A read on either port in the same cycle as a register write to the same word returns the word's old contents. The next read returns the new contents.
- R9: `reg_rdata` shows the whole 32-bit word one cycle after `reg_rd` and holds it until the next register read.
- R10: After the synchronous active-high reset, `pix_valid`, `reg_rdata` and the three colour outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_bytes | input | 1 | Big-endian byte order: inverts the half-word choice |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | Word address (index >> 1) |
| reg_be | input | 4 | Byte-lane write enables |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| pix_req | input | 1 | Pixel lookup request |
| pix_idx | input | 8 | Palette index |
| pix_valid | output | 1 | Colour outputs are fresh this cycle |
| pix_red | output | 5 | Red channel |
| pix_grn | output | 5 | Green channel |
| pix_blu | output | 5 | Blue channel |

## Verification
A register write and a pixel lookup of the same word can land in the same cycle. A register write and a register read of that word can also coincide. The bench drives each pair on one clock edge. It expects the lookup or read issued on that edge to return the pre-write word. It then issues a second lookup and read and expects them to return the merged new word. The other overlap is between the index's low bit and the byte-order control. Each of these picks a half. The bench sweeps all 256 indices under both settings against a model word array and checks that the two choices combine as an exclusive-or.

// File: rtl/hw_palette_pkg.sv
package hw_palette_pkg;
  localparam int CH_W   = 5;
  localparam int LANE_W = 8;

  typedef struct packed {
    logic [CH_W-1:0] blu;
    logic [CH_W-1:0] grn;
    logic [CH_W-1:0] red;
  } pal_rgb_t;

  function automatic pal_rgb_t unpack_entry(input logic [3*CH_W-1:0] e);
    pal_rgb_t c;
    c.red = e[CH_W-1:0];
    c.grn = e[2*CH_W-1:CH_W];
    c.blu = e[3*CH_W-1:2*CH_W];
    return c;
  endfunction
endpackage

// File: rtl/pal_lane_ram.sv
module pal_lane_ram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       a_rdata <= '0;
    else if (a_rd) a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)       b_rdata <= '0;
    else if (b_rd) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/pal_half_sel.sv
module pal_half_sel
  import hw_palette_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  logic              sel_hi,
  output pal_rgb_t          color
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] half;
  logic              unused_msb;

  always_comb begin
    half = sel_hi ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
  end

  assign unused_msb = half[HALF_W-1];
  assign color      = unpack_entry(half[3*CH_W-1:0]);
endmodule

// File: rtl/hw_palette.sv
module hw_palette
  import hw_palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  swap_bytes,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [IDX_W-2:0]      reg_addr,
  input  logic [WORD_W/8-1:0]   reg_be,
  input  logic [WORD_W-1:0]     reg_wdata,
  output logic [WORD_W-1:0]     reg_rdata,
  input  logic                  pix_req,
  input  logic [IDX_W-1:0]      pix_idx,
  output logic                  pix_valid,
  output logic [CH_W-1:0]       pix_red,
  output logic [CH_W-1:0]       pix_grn,
  output logic [CH_W-1:0]       pix_blu
);
  localparam int ADDR_W = IDX_W - 1;
  localparam int LANES  = WORD_W / LANE_W;

  logic [ADDR_W-1:0] pix_word_addr;
  logic [WORD_W-1:0] pix_word;
  logic              sel_hi_q;
  pal_rgb_t          color;

  assign pix_word_addr = pix_idx[IDX_W-1:1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pal_lane_ram #(
      .ADDR_W (ADDR_W),
      .DATA_W (LANE_W)
    ) u_lane (
      .clk     (clk),
      .rst     (rst),
      .a_wr    (reg_wr && reg_be[g]),
      .a_rd    (reg_rd),
      .a_addr  (reg_addr),
      .a_wdata (reg_wdata[g*LANE_W +: LANE_W]),
      .a_rdata (reg_rdata[g*LANE_W +: LANE_W]),
      .b_rd    (pix_req),
      .b_addr  (pix_word_addr),
      .b_rdata (pix_word[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      sel_hi_q  <= 1'b0;
    end else begin
      pix_valid <= pix_req;
      if (pix_req) sel_hi_q <= pix_idx[0] ^ swap_bytes;
    end
  end

  pal_half_sel #(
    .WORD_W (WORD_W)
  ) u_sel (
    .word   (pix_word),
    .sel_hi (sel_hi_q),
    .color  (color)
  );

  assign pix_red = color.red;
  assign pix_grn = color.grn;
  assign pix_blu = color.blu;
endmodule

// File: rtl/hw_palette_chk.sv
module hw_palette_chk #(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [IDX_W-2:0]    reg_addr,
  input logic [WORD_W/8-1:0] reg_be,
  input logic [WORD_W-1:0]   reg_wdata,
  input logic [WORD_W-1:0]   reg_rdata,
  input logic                pix_req,
  input logic                pix_valid,
  input logic [4:0]          pix_red,
  input logic [4:0]          pix_grn,
  input logic [4:0]          pix_blu
);
  AST_PIX_LATENCY: assert property (@(posedge clk) disable iff (rst)
    pix_req |=> pix_valid); // R7

  AST_PIX_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pix_req |=> (!pix_valid && $stable({pix_blu, pix_grn, pix_red}))); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata)); // R9

  AST_READ_AFTER_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_wr && $past(reg_wr) && ($past(reg_be) == '1) &&
     ($past(reg_addr) == reg_addr))
    |=> (reg_rdata == $past(reg_wdata, 2))); // R9
endmodule

bind hw_palette hw_palette_chk #(
  .IDX_W  (IDX_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_be    (reg_be),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pix_req   (pix_req),
  .pix_valid (pix_valid),
  .pix_red   (pix_red),
  .pix_grn   (pix_grn),
  .pix_blu   (pix_blu)
);

// File: tb/tb_hw_palette.sv
`timescale 1ns/1ps
module tb_hw_palette;
  logic        clk = 1'b0;
  logic        rst;
  logic        swap_bytes;
  logic        reg_wr, reg_rd;
  logic [6:0]  reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic        pix_req;
  logic [7:0]  pix_idx;
  logic        pix_valid;
  logic [4:0]  pix_red, pix_grn, pix_blu;

  int nchk = 0;
  int nbad = 0;
  bit finished = 0;
  logic [31:0] mdl [128];

  always #2.5 clk = ~clk;

  hw_palette dut (
    .clk(clk), .rst(rst), .swap_bytes(swap_bytes),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_req(pix_req), .pix_idx(pix_idx), .pix_valid(pix_valid),
    .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu)
  );

  function automatic logic [31:0] pat(input int k);
    return (32'(k) * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r;
    r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [14:0] exp_col(input logic [31:0] w, input int idx, input bit sw);
    logic sel;
    logic [15:0] h;
    sel = idx[0] ^ sw;
    h = sel ? w[31:16] : w[15:0];
    return h[14:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 7'(a); reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'h0;
    mdl[a] = merge(mdl[a], d, be);
  endtask

  task automatic rd(input int a, input string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 7'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    chk(reg_rdata == mdl[a], req, reg_rdata, mdl[a]);
  endtask

  task automatic px(input int idx, input bit sw, input string req);
    logic [14:0] e;
    @(negedge clk);
    pix_req = 1'b1; pix_idx = 8'(idx); swap_bytes = sw;
    @(negedge clk);
    pix_req = 1'b0;
    e = exp_col(mdl[idx >> 1], idx, sw);
    chk(pix_valid == 1'b1, "R7 valid", 32'(pix_valid), 32'd1);
    chk({pix_blu, pix_grn, pix_red} == e, req, 32'({pix_blu, pix_grn, pix_red}), 32'(e));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [14:0] held;
    logic [31:0] oldw;
    rst = 1'b1; swap_bytes = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = '0; reg_be = '0; reg_wdata = '0; pix_req = 1'b0; pix_idx = '0;
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    chk(pix_valid == 1'b0, "R10 pix_valid", 32'(pix_valid), 32'd0);
    chk(reg_rdata == 32'd0, "R10 reg_rdata", reg_rdata, 32'd0);
    chk({pix_blu, pix_grn, pix_red} == 15'd0, "R10 colour", 32'({pix_blu, pix_grn, pix_red}), 32'd0);

    // R1/R9: fill every word, read back
    for (int k = 0; k < 128; k++) wr(k, pat(k), 4'hF);
    for (int k = 0; k < 128; k++) rd(k, "R9 R1 full word readback");

    // R2/R4: all indices, little-endian; R3: all indices, swapped
    for (int i = 0; i < 256; i++) px(i, 1'b0, "R2 R4 little-endian lookup");
    for (int i = 0; i < 256; i++) px(i, 1'b1, "R3 swapped lookup");

    // R5: top bit of each half stored but not seen by pixel path
    wr(3, 32'h8000_8000 | 32'h2A5F_1234, 4'hF);
    rd(3, "R5 bit15 readback");
    px(6, 1'b0, "R5 low entry ignores bit15");
    px(7, 1'b0, "R5 high entry ignores bit15");

    // R6: every byte-enable pattern across the table
    for (int k = 0; k < 128; k++) wr(k, ~pat(k + 300), 4'(k % 16));
    for (int k = 0; k < 128; k++) begin
      rd(k, "R6 masked write");
      px(2 * k, k[0], "R6 even entry after masked write");
      px(2 * k + 1, k[1], "R6 odd entry after masked write");
    end

    // R8: pixel lookup colliding with a write to the same word
    for (int k = 10; k < 14; k++) begin
      oldw = mdl[k];
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 7'(k); reg_wdata = pat(k + 900); reg_be = 4'hF;
      pix_req = 1'b1; pix_idx = 8'(2 * k + 1); swap_bytes = 1'b0;
      @(negedge clk);
      reg_wr = 1'b0; reg_be = 4'h0; pix_req = 1'b0;
      chk({pix_blu, pix_grn, pix_red} == exp_col(oldw, 2 * k + 1, 1'b0), "R8 collision old",
          32'({pix_blu, pix_grn, pix_red}), 32'(exp_col(oldw, 2 * k + 1, 1'b0)));
      mdl[k] = merge(oldw, pat(k + 900), 4'hF);
      px(2 * k + 1, 1'b0, "R8 following lookup new");
    end

    // R8/R9: register read colliding with a write
    oldw = mdl[20];
    @(negedge clk);
    reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = 7'd20; reg_wdata = 32'hDEAD_BEEF; reg_be = 4'h3;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; reg_be = 4'h0;
    chk(reg_rdata == oldw, "R8 reg read collision old", reg_rdata, oldw);
    mdl[20] = merge(oldw, 32'hDEAD_BEEF, 4'h3);
    rd(20, "R8 reg read after collision new");

    // R7: outputs hold while idle
    px(41, 1'b0, "R7 lookup before idle");
    held = {pix_blu, pix_grn, pix_red};
    wr(20, 32'h0, 4'hF);
    swap_bytes = 1'b1;
    @(negedge clk);
    chk(pix_valid == 1'b0, "R7 valid drops", 32'(pix_valid), 32'd0);
    chk({pix_blu, pix_grn, pix_red} == held, "R7 colour holds",
        32'({pix_blu, pix_grn, pix_red}), 32'(held));

    finished = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule